// File: doc/BRIEF.md
# Serial Readout Controller for a 16-bit Converter

This block is the digital side of a converter that hands its result out over three wires: an active-low chip select and a serial clock, both driven by an external master, and a serial data line driven by the block. It runs a fixed loop of three phases: a conversion of programmable length, a wait with the result held, and a readout. A cycle counter stands in for the conversion time. A parallel sample input stands in for the modulator and filter result, and it is captured when each conversion finishes.

Both master inputs are brought into the system clock domain through two-flop synchronizers, and edges are found on the synchronized copies. The master opens a readout by holding both chip select and the serial clock low. It captures each bit on a rising clock edge, and the block moves to the next bit on each falling edge. Raising chip select ends the readout at once. A readout that ends either way starts a new conversion immediately. While the block waits with chip select high, it raises a low-power flag.

Top module: `adc_rd_ctrl`

## Requirements
- R1: After reset is released, a conversion of CONV_CYCLES system clocks runs. It then ends in the wait phase, where the sample input is captured.
- R2: Activity on chip select or the serial clock during a conversion does not shorten or disturb it.
- R3: In the wait phase, readout starts only when the synchronized chip select and serial clock are both low. Chip select low with the clock high leaves the block waiting and the data line idle.
- R4: `low_pwr` is 1 exactly while waiting with chip select high. It drops when chip select goes low, even with the clock held high, and returns when chip select rises again.
- R5: The captured result does not change while waiting, whatever the sample input does.
- R6: When readout starts, `sdo` at once shows bit 15 of the held result.
- R7: Each falling serial clock edge moves `sdo` to the next lower bit, so bits leave most significant first.
- R8: The 16th falling edge ends the readout. `sdo` returns to idle (1) and a new full-length conversion starts.
- R9: A rising chip select during readout aborts it at once: `sdo_oe` drops, and a new full-length conversion starts. A new result is then read from bit 15.
- R10: `sdo_oe` follows the synchronized inverse of chip select. Outside readout, `sdo` is 1.
- R11: While reset is asserted, `sdo_oe` and `low_pwr` are 0 and `sdo` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select from master, active low |
| sclk | input | 1 | Serial clock from master |
| sample_i | input | DW | Parallel conversion result, captured at end of conversion |
| sdo | output | 1 | Serial data, most significant bit first |
| sdo_oe | output | 1 | Data line drive enable (models the tri-state) |
| low_pwr | output | 1 | Low-power indication while waiting with chip select high |

## Verification
Two ends of a readout can fall in the same system clock cycle: the rising chip select that aborts it, and the 16th falling serial clock edge that completes it. The bench provokes this by dropping the serial clock and raising chip select on the same cycle after fifteen bits. It judges the result by the timing of the following conversion, which must be exactly one full length with no double start. It then reads the next result, which must begin cleanly from bit 15.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;
  typedef enum logic [1:0] {
    PH_CONV  = 2'd0,
    PH_SLEEP = 2'd1,
    PH_SHIFT = 2'd2
  } phase_e;
endpackage

// File: rtl/adc_rd_rst_sync.sv
module adc_rd_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= 2'b00;
    else        stg_q <= {stg_q[0], 1'b1};
  end

  assign rst_sync_n = stg_q[1];
endmodule

// File: rtl/adc_rd_sync.sv
module adc_rd_sync #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic m_q, s_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_q <= RST_VAL;
      s_q <= RST_VAL;
    end else begin
      m_q <= d;
      s_q <= m_q;
    end
  end

  assign q = s_q;
endmodule

// File: rtl/adc_rd_conv_timer.sv
module adc_rd_conv_timer #(
  parameter int CONV_CYCLES = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic done
);
  localparam int CW = (CONV_CYCLES > 1) ? $clog2(CONV_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(CONV_CYCLES - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    done   = run && (cnt_q == LAST);
    cnt_en = 1'b1;
    if (!run || done) cnt_d = '0;
    else              cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/adc_rd_shifter.sv
module adc_rd_shifter #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap,
  input  logic [DW-1:0] samp,
  input  logic          load,
  input  logic          adv,
  output logic [DW-1:0] held,
  output logic          bit_o,
  output logic          last
);
  localparam int BW = (DW > 1) ? $clog2(DW) : 1;
  localparam logic [BW-1:0] LAST_IDX = BW'(DW - 1);

  logic [DW-1:0] held_q, sh_q, sh_d;
  logic [BW-1:0] idx_q, idx_d;
  logic          sh_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   held_q <= '0;
    else if (cap) held_q <= samp;
  end

  always_comb begin
    sh_en = load || adv;
    sh_d  = sh_q;
    idx_d = idx_q;
    if (load) begin
      sh_d  = held_q;
      idx_d = '0;
    end else if (adv) begin
      sh_d  = {sh_q[DW-2:0], 1'b0};
      idx_d = idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      idx_q <= '0;
    end else if (sh_en) begin
      sh_q  <= sh_d;
      idx_q <= idx_d;
    end
  end

  assign held  = held_q;
  assign bit_o = sh_q[DW-1];
  assign last  = (idx_q == LAST_IDX);
endmodule

// File: rtl/adc_rd_ctrl.sv
module adc_rd_ctrl #(
  parameter int DW          = 16,
  parameter int CONV_CYCLES = 1000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          sclk,
  input  logic [DW-1:0] sample_i,
  output logic          sdo,
  output logic          sdo_oe,
  output logic          low_pwr
);
  import adc_rd_pkg::*;

  logic   rst_int_n;
  logic   cs_s, sclk_s, cs_q, sclk_q;
  logic   cs_rise, sclk_fall;
  logic   conv_done, cap, load, adv, sh_bit, sh_last;
  logic [DW-1:0] held;
  phase_e phase_q, phase_d;

  adc_rd_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_int_n));

  adc_rd_sync #(.RST_VAL(1'b1)) u_cs_sync (
    .clk(clk), .rst_n(rst_int_n), .d(cs_n), .q(cs_s));
  adc_rd_sync #(.RST_VAL(1'b0)) u_sclk_sync (
    .clk(clk), .rst_n(rst_int_n), .d(sclk), .q(sclk_s));

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      cs_q   <= 1'b1;
      sclk_q <= 1'b0;
    end else begin
      cs_q   <= cs_s;
      sclk_q <= sclk_s;
    end
  end

  assign cs_rise   = cs_s && !cs_q;
  assign sclk_fall = sclk_q && !sclk_s;

  adc_rd_conv_timer #(.CONV_CYCLES(CONV_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_int_n), .run(phase_q == PH_CONV), .done(conv_done));

  always_comb begin
    phase_d = phase_q;
    case (phase_q)
      PH_CONV:  if (conv_done) phase_d = PH_SLEEP;
      PH_SLEEP: if (!cs_s && !sclk_s) phase_d = PH_SHIFT;
      PH_SHIFT: begin
        if (cs_rise)                   phase_d = PH_CONV;
        else if (sclk_fall && sh_last) phase_d = PH_CONV;
      end
      default:  phase_d = PH_CONV;
    endcase
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) phase_q <= PH_CONV;
    else            phase_q <= phase_d;
  end

  assign cap  = conv_done;
  assign load = (phase_q == PH_SLEEP) && (phase_d == PH_SHIFT);
  assign adv  = (phase_q == PH_SHIFT) && sclk_fall && !cs_rise;

  adc_rd_shifter #(.DW(DW)) u_shift (
    .clk(clk), .rst_n(rst_int_n), .cap(cap), .samp(sample_i),
    .load(load), .adv(adv), .held(held), .bit_o(sh_bit), .last(sh_last));

  assign sdo     = (phase_q == PH_SHIFT) ? sh_bit : 1'b1;
  assign sdo_oe  = !cs_s;
  assign low_pwr = (phase_q == PH_SLEEP) && cs_s;
endmodule

// File: rtl/adc_rd_ctrl_chk.sv
module adc_rd_ctrl_chk
  import adc_rd_pkg::*;
#(
  parameter int DW          = 16,
  parameter int CONV_CYCLES = 1000
) (
  input logic          clk,
  input logic          rst_n,
  input phase_e        phase,
  input logic          cs_s,
  input logic          sclk_s,
  input logic [DW-1:0] held,
  input logic          sdo
);
  localparam int CW = (CONV_CYCLES > 1) ? $clog2(CONV_CYCLES) + 1 : 2;
  localparam logic [CW-1:0] LAST = CW'(CONV_CYCLES - 1);

  logic [CW-1:0] ccnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                ccnt_q <= '0;
    else if (phase == PH_CONV) ccnt_q <= ccnt_q + 1'b1;
    else                       ccnt_q <= '0;
  end

  a_r2_no_early_end: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_CONV && ccnt_q != LAST) |=> phase == PH_CONV);

  a_r1_conv_length: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_CONV && ccnt_q == LAST) |=> phase == PH_SLEEP);

  a_r3_sleep_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_SLEEP && (cs_s || sclk_s)) |=> phase == PH_SLEEP);

  a_r5_hold_result: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_SLEEP) |=> $stable(held));

  a_r6_msb_first: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_SHIFT && $past(phase) == PH_SLEEP) |-> sdo == held[DW-1]);

  a_r9_abort: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_SHIFT && $rose(cs_s)) |=> phase == PH_CONV);
endmodule

bind adc_rd_ctrl adc_rd_ctrl_chk #(.DW(DW), .CONV_CYCLES(CONV_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_int_n), .phase(phase_q), .cs_s(cs_s),
  .sclk_s(sclk_s), .held(held), .sdo(sdo));

// File: tb/adc_rd_ctrl_tb.sv
module adc_rd_ctrl_tb;
  localparam int DW = 16;
  localparam int CC = 40;
  localparam int HP = 6;

  typedef struct {
    logic b;
    int   idx;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n, cs_n, sclk;
  logic [DW-1:0] sample_i;
  logic sdo, sdo_oe, low_pwr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  exp_t sb_q[$];
  event smp_ev;

  always #5 clk = ~clk;

  adc_rd_ctrl #(.DW(DW), .CONV_CYCLES(CC)) u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk),
    .sample_i(sample_i), .sdo(sdo), .sdo_oe(sdo_oe), .low_pwr(low_pwr));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic waitn(input int n);
    repeat (n) @(negedge clk);
  endtask

  // scoreboard monitor: pops one expected bit per sample point
  initial begin
    forever begin
      exp_t e;
      @(smp_ev);
      if (sb_q.size() == 0) begin
        chk("R7 unexpected sample", 0, 1);
      end else begin
        e = sb_q.pop_front();
        if (e.idx == 0) chk("R6 first bit is bit15", {31'd0, sdo}, {31'd0, e.b});
        else            chk("R7 next bit", {31'd0, sdo}, {31'd0, e.b});
        chk("R10 oe during readout", {31'd0, sdo_oe}, 32'd1);
      end
    end
  end

  // conversion window measured from the current negedge; cs high unless toggling
  task automatic conv_window(input string tag, input logic [DW-1:0] val, input bit toggle);
    sample_i = val;
    for (int n = 1; n <= CC + 5; n++) begin
      @(negedge clk);
      if (toggle && n < CC - 10) begin
        cs_n = n[2];
        sclk = n[1];
      end else if (toggle && n == CC - 10) begin
        cs_n = 1'b1;
        sclk = 1'b0;
      end
      if (!toggle && n == 4) begin
        chk({tag, " idle sdo"}, {31'd0, sdo}, 32'd1);
        chk({tag, " oe off"}, {31'd0, sdo_oe}, 32'd0);
      end
      if (n == CC - 10) chk({tag, " still converting"}, {31'd0, low_pwr}, 32'd0);
    end
    chk({tag, " conversion ended"}, {31'd0, low_pwr}, 32'd1);
    sample_i = ~val ^ 16'h1234;  // R5: input moves during wait
  endtask

  // readout driver: pushes expected bits, clocks nbits, optional coincident end
  task automatic read_bits(input logic [DW-1:0] val, input int nbits,
                           input bit pre_hi, input bit coincide);
    if (pre_hi) begin
      sclk = 1'b1;
      cs_n = 1'b0;
      waitn(HP);
      chk("R4 flag clears cs low sclk high", {31'd0, low_pwr}, 32'd0);
      chk("R3 no readout while sclk high", {31'd0, sdo}, 32'd1);
      chk("R10 oe follows cs", {31'd0, sdo_oe}, 32'd1);
      cs_n = 1'b1;
      waitn(HP);
      chk("R4 flag returns cs high", {31'd0, low_pwr}, 32'd1);
      cs_n = 1'b0;
      waitn(HP);
      sclk = 1'b0;
    end else begin
      cs_n = 1'b0;
    end
    waitn(HP);
    for (int i = 0; i < nbits; i++) begin
      exp_t e;
      e.b = val[DW-1-i];
      e.idx = i;
      sb_q.push_back(e);
      -> smp_ev;
      sclk = 1'b1;
      waitn(HP);
      sclk = 1'b0;
      if (coincide && i == nbits - 1) cs_n = 1'b1;
      if (i != nbits - 1) waitn(HP);
    end
  endtask

  initial begin
    rst_n = 1'b0;
    cs_n = 1'b1;
    sclk = 1'b0;
    sample_i = 16'hA5C3;
    waitn(5);
    chk("R11 reset oe", {31'd0, sdo_oe}, 32'd0);
    chk("R11 reset low_pwr", {31'd0, low_pwr}, 32'd0);
    chk("R11 reset sdo", {31'd0, sdo}, 32'd1);
    rst_n = 1'b1;
    conv_window("R1", 16'hA5C3, 1'b0);

    // full readout after sleep with cs low / sclk high excursion (R3, R4, R5)
    read_bits(16'hA5C3, 16, 1'b1, 1'b0);
    waitn(4);
    chk("R8 sdo idle after 16th fall", {31'd0, sdo}, 32'd1);
    chk("R8 oe still on", {31'd0, sdo_oe}, 32'd1);
    cs_n = 1'b1;
    conv_window("R8", 16'h3C96, 1'b0);

    // abort after five bits
    read_bits(16'h3C96, 5, 1'b0, 1'b0);
    waitn(HP);
    cs_n = 1'b1;
    conv_window("R9", 16'h8001, 1'b0);
    read_bits(16'h8001, 16, 1'b0, 1'b0);
    waitn(4);
    cs_n = 1'b1;

    // conversion with pin activity
    conv_window("R2", 16'h5AF0, 1'b1);
    read_bits(16'h5AF0, 16, 1'b0, 1'b1);  // 16th fall together with cs rise
    conv_window("R9 coincident end", 16'h7E18, 1'b0);
    read_bits(16'h7E18, 16, 1'b0, 1'b0);
    waitn(4);
    cs_n = 1'b1;
    waitn(10);
    chk("R7 scoreboard drained", sb_q.size(), 0);
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule